// File: doc/BRIEF.md
# MDIO Management Controller

This block is a management-interface master for Ethernet PHYs. A host processor talks to it through a small register port with two locations: a command word and a data word. The command word carries the target PHY address, the PHY register number, a write flag and a go/busy bit. The data word holds the value to be written or the value that was read back. The block turns each command into a standard 64-bit management frame on the MDC clock and the bidirectional MDIO line. MDIO is driven through an output-enable so that it can be released to a pad buffer.

A read starts as soon as the command word is written with go set. A write is armed by the command word and held back until the host writes the data word. Only then is the frame shifted out, so the data phase always carries the value the host intended. Busy stays set from the accepting write until the last MDC falling edge of the frame, and then the hardware clears it. Command writes made while busy are dropped, and so are data writes made while a frame is shifting.

MDC is made from the system clock by a parameterised half-period divider. The default keeps MDC at 2.5 MHz from a 100 MHz clock. MDC stays low between frames.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word and the data word both read as zero, busy is clear, MDC is low and the MDIO output-enable is low.
- R2: In the command word (host_sel=0) the PHY address sits in bits [15:11], the register number in bits [10:6], the write flag in bit 1 (1 = write, 0 = read) and go/busy in bit 0. All other bits read as zero. A command write with bit 0 clear only stores the fields and starts no frame.
- R3: A read frame is, MSB first: 32 ones, start 01, opcode 10, 5-bit PHY address, 5-bit register number. The block drives MDIO only for these first 46 bits and releases it (output-enable low) for the turnaround and the 16 data bits.
- R4: On a read, the 16 data bits are sampled from MDIO on the MDC rising edges of the data phase, MSB first. They appear in bits [15:0] of the data word (host_sel=1) once busy has cleared, and bits [31:16] read zero.
- R5: A write frame is 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the 16-bit data word MSB first, with the output-enable high for all 64 bits.
- R6: After a command write with go=1 and write=1, busy reads 1, but MDC stays low and no frame starts until the data word is written. That data write starts the frame.
- R7: Each MDC half period lasts DIV_HALF system clocks. A frame has exactly 64 MDC rising edges, MDIO changes only on MDC falling edges, and MDC is low whenever no frame is running.
- R8: Busy clears by itself exactly 2*DIV_HALF*64+1 clock edges after the write that starts the frame (the command write for a read, the data write for a write).
- R9: A command write while busy is ignored: the stored fields do not change and no extra frame is started.
- R10: A data write while idle is stored and reads back in bits [15:0]. A data write while a frame is shifting is ignored, and the frame and the data word keep the earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Register select: 0 command word, 1 data word |
| host_wdata | input | BUS_W | Host write data |
| host_rdata | output | BUS_W | Read view of the selected register (combinational) |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output-enable (1 = block drives the line) |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The host write that starts a frame lands on one clock edge. One further registered cycle passes before shifting begins, so busy is due to clear exactly 2*DIV_HALF*64+1 edges later. The bench counts falling-edge samples from the write to the first busy-clear reading and compares that count with the value it computes. The frame content is not checked against clock counts. A PHY model keyed to MDC rising edges records MDIO and its enable and feeds reply bits back a full MDC period ahead of the edge that samples them. Register read-backs are taken half a clock after the edge that updates them, so each result is read one cycle after its write at the earliest.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   typedef enum logic [1:0] {
      HST_IDLE     = 2'd0,
      HST_WAITDATA = 2'd1,
      HST_SHIFT    = 2'd2
   } host_state_t;

   // frame symbols
   localparam logic [1:0] FRM_START = 2'b01;
   localparam logic [1:0] FRM_OP_RD = 2'b10;
   localparam logic [1:0] FRM_OP_WR = 2'b01;
   localparam logic [1:0] FRM_TA_WR = 2'b10;

   // command word layout (software-visible)
   localparam int CMD_GO_BIT  = 0;
   localparam int CMD_WR_BIT  = 1;
   localparam int CMD_REG_LSB = 6;

   localparam logic HSEL_CMD  = 1'b0;
   localparam logic HSEL_DATA = 1'b1;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_HALF = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic mdc_o,
   output logic rise_stb_o,
   output logic fall_stb_o
);

   logic tick;
   logic mdc_q;

   generate
      if (DIV_HALF == 1) begin : g_direct
         assign tick = en;
      end else begin : g_count
         localparam int CNT_W = $clog2(DIV_HALF);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (!en)             cnt_q <= '0;
            else if (cnt_q == CNT_LAST) cnt_q <= '0;
            else                      cnt_q <= cnt_q + 1'b1;
         end

         assign tick = en && (cnt_q == CNT_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mdc_q <= 1'b0;
      else if (!en)   mdc_q <= 1'b0;
      else if (tick)  mdc_q <= ~mdc_q;
   end

   assign mdc_o      = mdc_q;
   assign rise_stb_o = tick && !mdc_q;
   assign fall_stb_o = tick && mdc_q;

   // R7: clock parks low when disabled
   assert_mdc_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !mdc_o);

   // R7: a rise strobe is followed by MDC high
   assert_rise_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb_o |=> mdc_o);

endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift import mdio_mgmt_pkg::*; #(
   parameter int PREAMBLE_LEN = 32,
   parameter int PHY_AW       = 5,
   parameter int REG_AW       = 5,
   parameter int DATA_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wr_i,
   input  logic [PHY_AW-1:0] phy_i,
   input  logic [REG_AW-1:0] reg_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_i,
   output logic              active_o,
   output logic              done_o,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int FRAME_LEN  = PREAMBLE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
   localparam int TA_FIRST   = PREAMBLE_LEN + 4 + PHY_AW + REG_AW;
   localparam int DATA_FIRST = TA_FIRST + 2;
   localparam int BIT_W      = $clog2(FRAME_LEN);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_LEN - 1);
   localparam logic [BIT_W-1:0] BIT_TA   = BIT_W'(TA_FIRST);
   localparam logic [BIT_W-1:0] BIT_DATA = BIT_W'(DATA_FIRST);

   logic                 active_q;
   logic                 wr_q;
   logic [BIT_W-1:0]     bitn_q;
   logic [FRAME_LEN-1:0] frame_q;
   logic [DATA_W-1:0]    rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         wr_q     <= 1'b0;
         bitn_q   <= '0;
         frame_q  <= '1;
         rd_q     <= '0;
      end else if (start_i && !active_q) begin
         active_q <= 1'b1;
         wr_q     <= wr_i;
         bitn_q   <= '0;
         frame_q  <= {{PREAMBLE_LEN{1'b1}}, FRM_START,
                      (wr_i ? FRM_OP_WR : FRM_OP_RD), phy_i, reg_i,
                      (wr_i ? FRM_TA_WR : 2'b11),
                      (wr_i ? wdata_i : {DATA_W{1'b1}})};
      end else if (active_q) begin
         if (rise_stb && !wr_q && (bitn_q >= BIT_DATA))
            rd_q <= {rd_q[DATA_W-2:0], mdio_i};
         if (fall_stb) begin
            if (bitn_q == BIT_LAST) begin
               active_q <= 1'b0;
            end else begin
               bitn_q  <= bitn_q + 1'b1;
               frame_q <= {frame_q[FRAME_LEN-2:0], 1'b1};
            end
         end
      end
   end

   assign active_o  = active_q;
   assign done_o    = active_q && fall_stb && (bitn_q == BIT_LAST);
   assign mdio_o    = active_q ? frame_q[FRAME_LEN-1] : 1'b1;
   assign mdio_oe   = active_q && (wr_q || (bitn_q < BIT_TA));
   assign rd_data_o = rd_q;

   // R3: leaving the last address bit of a read releases the line
   assert_read_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !wr_q && fall_stb && (bitn_q == BIT_TA - 1'b1)) |=> !mdio_oe);

   // R7: a frame never ends before its final bit
   assert_frame_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && fall_stb && (bitn_q != BIT_LAST)) |=> active_o);

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs import mdio_mgmt_pkg::*; #(
   parameter int BUS_W  = 32,
   parameter int PHY_AW = 5,
   parameter int REG_AW = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_sel,
   input  logic [BUS_W-1:0]  host_wdata,
   output logic [BUS_W-1:0]  host_rdata,
   output logic              start_o,
   output logic              wr_o,
   output logic [PHY_AW-1:0] phy_o,
   output logic [REG_AW-1:0] reg_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              busy_o,
   input  logic              eng_active,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_rd_data
);

   localparam int PHY_LSB = CMD_REG_LSB + REG_AW;

   host_state_t       state_q;
   logic              start_q;
   logic              wr_q;
   logic [PHY_AW-1:0] phy_q;
   logic [REG_AW-1:0] reg_q;
   logic [DATA_W-1:0] data_q;

   logic cmd_wr;
   logic data_wr;
   assign cmd_wr  = host_wr && (host_sel == HSEL_CMD);
   assign data_wr = host_wr && (host_sel == HSEL_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HST_IDLE;
         start_q <= 1'b0;
         wr_q    <= 1'b0;
         phy_q   <= '0;
         reg_q   <= '0;
         data_q  <= '0;
      end else begin
         start_q <= 1'b0;
         case (state_q)
            HST_IDLE: begin
               if (cmd_wr) begin
                  phy_q <= host_wdata[PHY_LSB +: PHY_AW];
                  reg_q <= host_wdata[CMD_REG_LSB +: REG_AW];
                  wr_q  <= host_wdata[CMD_WR_BIT];
                  if (host_wdata[CMD_GO_BIT]) begin
                     if (host_wdata[CMD_WR_BIT]) begin
                        state_q <= HST_WAITDATA;
                     end else begin
                        state_q <= HST_SHIFT;
                        start_q <= 1'b1;
                     end
                  end
               end
               if (data_wr) data_q <= host_wdata[DATA_W-1:0];
            end
            HST_WAITDATA: begin
               if (data_wr) begin
                  data_q  <= host_wdata[DATA_W-1:0];
                  state_q <= HST_SHIFT;
                  start_q <= 1'b1;
               end
            end
            HST_SHIFT: begin
               if (eng_done) begin
                  state_q <= HST_IDLE;
                  if (!wr_q) data_q <= eng_rd_data;
               end
            end
            default: state_q <= HST_IDLE;
         endcase
      end
   end

   assign busy_o  = (state_q != HST_IDLE);
   assign start_o = start_q;
   assign wr_o    = wr_q;
   assign phy_o   = phy_q;
   assign reg_o   = reg_q;
   assign wdata_o = data_q;

   always_comb begin
      host_rdata = '0;
      if (host_sel == HSEL_CMD) begin
         host_rdata[PHY_LSB +: PHY_AW]     = phy_q;
         host_rdata[CMD_REG_LSB +: REG_AW] = reg_q;
         host_rdata[CMD_WR_BIT]            = wr_q;
         host_rdata[CMD_GO_BIT]            = busy_o;
      end else begin
         host_rdata[DATA_W-1:0] = data_q;
      end
   end

   // R8: busy only drops on the frame's completion
   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !eng_done) |=> busy_o);

   // R9: command writes while busy leave the fields alone
   assert_cmd_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cmd_wr) |=> ($stable(phy_q) && $stable(reg_q) && $stable(wr_q)));

   // R10: data writes during shifting leave the data word alone
   assert_data_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == HST_SHIFT) && data_wr && !eng_done) |=> $stable(data_q));

   // R6: no shifting while waiting for write data
   assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == HST_WAITDATA) |-> !eng_active);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl import mdio_mgmt_pkg::*; #(
   parameter int BUS_W        = 32,
   parameter int PHY_AW       = 5,
   parameter int REG_AW       = 5,
   parameter int DATA_W       = 16,
   parameter int PREAMBLE_LEN = 32,
   parameter int DIV_HALF     = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_sel,
   input  logic [BUS_W-1:0] host_wdata,
   output logic [BUS_W-1:0] host_rdata,
   output logic             mdc_o,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);

   localparam int PHY_MSB = CMD_REG_LSB + REG_AW + PHY_AW - 1;

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
      if (PHY_MSB >= BUS_W) begin : g_bad_cmd
         $error("command fields do not fit in BUS_W");
      end
      if (DATA_W > BUS_W || DATA_W < 2) begin : g_bad_data
         $error("DATA_W must lie in 2..BUS_W");
      end
      if (PREAMBLE_LEN < 1) begin : g_bad_pre
         $error("PREAMBLE_LEN must be positive");
      end
   endgenerate

   logic              start;
   logic              wr;
   logic [PHY_AW-1:0] phy;
   logic [REG_AW-1:0] regn;
   logic [DATA_W-1:0] wdata;
   logic              busy;
   logic              eng_active;
   logic              eng_done;
   logic [DATA_W-1:0] rd_data;
   logic              rise_stb;
   logic              fall_stb;

   mdio_host_regs #(
      .BUS_W (BUS_W),
      .PHY_AW(PHY_AW),
      .REG_AW(REG_AW),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_sel   (host_sel),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .start_o    (start),
      .wr_o       (wr),
      .phy_o      (phy),
      .reg_o      (regn),
      .wdata_o    (wdata),
      .busy_o     (busy),
      .eng_active (eng_active),
      .eng_done   (eng_done),
      .eng_rd_data(rd_data)
   );

   mdio_clk_div #(
      .DIV_HALF(DIV_HALF)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (eng_active),
      .mdc_o     (mdc_o),
      .rise_stb_o(rise_stb),
      .fall_stb_o(fall_stb)
   );

   mdio_frame_shift #(
      .PREAMBLE_LEN(PREAMBLE_LEN),
      .PHY_AW      (PHY_AW),
      .REG_AW      (REG_AW),
      .DATA_W      (DATA_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .wr_i     (wr),
      .phy_i    (phy),
      .reg_i    (regn),
      .wdata_i  (wdata),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .active_o (eng_active),
      .done_o   (eng_done),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_data_o(rd_data)
   );

   // R7: the engine runs only while the host side reports busy
   assert_active_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_active |-> busy);

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb_top;

   localparam int DIV = 2;
   localparam int FRAME_CYC = 2 * DIV * 64 + 1;
   localparam logic [63:0] RD_OE = 64'hFFFF_FFFF_FFFC_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_sel = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        mdc_o;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int failures = 0;
   bit timed_out = 1'b0;

   // PHY model state
   logic [63:0] cap_o;
   logic [63:0] cap_oe;
   int          rise_cnt = 64;
   logic [15:0] reply_q = '0;

   always #5 clk = ~clk;

   mdio_mgmt_ctrl #(.DIV_HALF(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   function automatic logic reply_bit(input int n);
      if (n >= 48 && n < 64) return reply_q[63 - n];
      if (n == 47) return 1'b0;
      return 1'b1;
   endfunction

   always @(posedge mdc_o) begin
      if (rise_cnt < 64) begin
         cap_o[63 - rise_cnt]  = mdio_o;
         cap_oe[63 - rise_cnt] = mdio_oe;
      end
      rise_cnt = rise_cnt + 1;
      mdio_i = reply_bit(rise_cnt);
   end

   function automatic logic [31:0] cmd_word(input int phy, input int rg,
                                            input bit wr, input bit go);
      return (32'(phy) << 11) | (32'(rg) << 6) | (32'(wr) << 1) | 32'(go);
   endfunction

   function automatic logic [63:0] exp_frame(input bit wr, input int phy,
                                             input int rg, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), 5'(phy), 5'(rg),
              (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic sel, input logic [31:0] d);
      @(negedge clk);
      host_sel = sel; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic sel, output logic [31:0] v);
      host_sel = sel;
      #1;
      v = host_rdata;
   endtask

   // counts falling edges from the write edge until busy reads clear
   task automatic wait_idle(output int cyc);
      logic [31:0] v;
      cyc = 0;
      hread(1'b0, v);
      while (v[0] && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         hread(1'b0, v);
      end
   endtask

   task automatic do_read(input int phy, input int rg, input logic [15:0] rep);
      int cyc;
      logic [31:0] v;
      reply_q = rep;
      rise_cnt = 0;
      hwrite(1'b0, cmd_word(phy, rg, 1'b0, 1'b1));
      wait_idle(cyc);
      chk("R8 read busy cycles", 64'(cyc), 64'(FRAME_CYC));
      chk("R7 read mdc rises", 64'(rise_cnt), 64'd64);
      chk("R3 read oe pattern", cap_oe, RD_OE);
      chk("R3 read header", cap_o & RD_OE, exp_frame(1'b0, phy, rg, rep) & RD_OE);
      hread(1'b1, v);
      chk("R4 read data", 64'(v), {48'd0, rep});
   endtask

   task automatic do_write(input int phy, input int rg, input logic [15:0] d);
      int cyc;
      logic [31:0] v;
      reply_q = 16'h0;
      rise_cnt = 0;
      hwrite(1'b0, cmd_word(phy, rg, 1'b1, 1'b1));
      repeat (30) @(negedge clk);
      hread(1'b0, v);
      chk("R6 armed busy", 64'(v[0]), 64'd1);
      chk("R6 no mdc before data", 64'(rise_cnt), 64'd0);
      chk("R6 mdc low while armed", 64'(mdc_o), 64'd0);
      hwrite(1'b1, 32'(d));
      wait_idle(cyc);
      chk("R8 write busy cycles", 64'(cyc), 64'(FRAME_CYC));
      chk("R7 write mdc rises", 64'(rise_cnt), 64'd64);
      chk("R5 write oe", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R5 write frame", cap_o, exp_frame(1'b1, phy, rg, d));
   endtask

   task automatic run_tests();
      logic [31:0] v;
      int cyc;
      int hi_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      hread(1'b0, v);
      chk("R1 command after reset", 64'(v), 64'd0);
      hread(1'b1, v);
      chk("R1 data after reset", 64'(v), 64'd0);
      chk("R1 mdc after reset", 64'(mdc_o), 64'd0);
      chk("R1 oe after reset", 64'(mdio_oe), 64'd0);

      // R2 fields stored without go; stray bits read as zero
      rise_cnt = 0;
      hwrite(1'b0, 32'hA5A5_0000 | cmd_word(21, 10, 1'b1, 1'b0) | 32'h3C);
      hread(1'b0, v);
      chk("R2 command layout", 64'(v), 64'(cmd_word(21, 10, 1'b1, 1'b0)));
      repeat (20) @(negedge clk);
      chk("R2 no frame without go", 64'(rise_cnt), 64'd0);

      // R10 idle data write stored
      hwrite(1'b1, 32'hDEAD_BEEF);
      hread(1'b1, v);
      chk("R10 idle data readback", 64'(v), 64'h0000_BEEF);

      // R7 MDC high time measured in system clocks
      reply_q = 16'h0;
      rise_cnt = 0;
      hwrite(1'b0, cmd_word(4, 4, 1'b0, 1'b1));
      while (!mdc_o) @(negedge clk);
      hi_cnt = 0;
      while (mdc_o) begin @(negedge clk); hi_cnt++; end
      chk("R7 mdc half period", 64'(hi_cnt), 64'(DIV));
      wait_idle(cyc);

      // R9 command write during a read frame is dropped
      reply_q = 16'h8001;
      rise_cnt = 0;
      hwrite(1'b0, cmd_word(9, 3, 1'b0, 1'b1));
      repeat (40) @(negedge clk);
      hwrite(1'b0, cmd_word(1, 2, 1'b1, 1'b1));
      wait_idle(cyc);
      hread(1'b0, v);
      chk("R9 fields unchanged", 64'(v), 64'(cmd_word(9, 3, 1'b0, 1'b0)));
      repeat (30) @(negedge clk);
      hread(1'b0, v);
      chk("R9 no second frame busy", 64'(v[0]), 64'd0);
      chk("R9 no second frame mdc", 64'(rise_cnt), 64'd64);
      hread(1'b1, v);
      chk("R4 read data top bit", 64'(v), 64'h8001);

      // R10 data write during a write frame is dropped
      rise_cnt = 0;
      hwrite(1'b0, cmd_word(17, 29, 1'b1, 1'b1));
      hwrite(1'b1, 32'h0000_1234);
      repeat (40) @(negedge clk);
      hwrite(1'b1, 32'h0000_FFFF);
      wait_idle(cyc);
      chk("R10 frame keeps data", cap_o, exp_frame(1'b1, 17, 29, 16'h1234));
      hread(1'b1, v);
      chk("R10 data word kept", 64'(v), 64'h1234);

      // sweep over every PHY address for reads and writes
      for (int p = 0; p < 32; p++) begin
         do_read(p, 31 - p, 16'(p * 16'h0843) ^ 16'hA5C3);
         do_write(p, (p * 3) % 32, ~(16'(p * 16'h1111) ^ 16'h5A0F));
      end
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      if (timed_out) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=expired expected=finished");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule